// File: doc/BRIEF.md
# Row-Column Decoded Byte RAM

A small byte-wide random-access memory of 2^N cells, with N even, laid out as a square grid of 2^(N/2) rows by 2^(N/2) columns. The address is not decoded into 2^N lines. Its upper half drives a one-hot row decoder and its lower half drives a one-hot column decoder. A cell takes part in an access only where its row line and its column line are both high. This needs 2·2^(N/2) select lines in total: 32 instead of 256 at the default N = 8.

The RAM is not reached through a raw bus. It is reached through two latched registers. The address register holds the location being accessed. The data register is two-way: it is loaded from outside before a write, and it is filled from the selected cell by a read.

A typical store takes two cycles. The first cycle loads the address and the data together. The second cycle issues the write. A typical fetch also takes two cycles: load the address, then issue the read. The value read is then on `mdr_q`.

Top module: `grid_ram`

## Requirements
- R1: On a rising edge with `addr_ld` high, `mar_q` takes `addr_in`; with `addr_ld` low it keeps its value.
- R2: While `en` is high, `row_sel` has exactly one bit set, at bit index `mar_q[N-1:N/2]`.
- R3: While `en` is high, `col_sel` has exactly one bit set, at bit index `mar_q[N/2-1:0]`.
- R4: While `en` is low, every bit of `row_sel` and `col_sel` is zero.
- R5: A read (`en` and `rd_req` high at an edge) loads `mdr_q` with the cell at the address held in `mar_q` before that edge, and leaves the cell unchanged.
- R6: A write (`en` and `wr_req` high and `rd_req` low at an edge) stores the `mdr_q` value from before that edge into the addressed cell. No other cell changes.
- R7: With `data_ld` high and no read in the same edge, `mdr_q` takes `data_in`; when a read and `data_ld` coincide, the read wins.
- R8: `rd_req` and `wr_req` high together act as a read alone: `mdr_q` takes the cell, and the cell is not written.
- R9: Asynchronous active-low reset clears `mar_q`, `mdr_q` and every cell to zero.
- R10: With `en` low, `rd_req` and `wr_req` have no effect on `mdr_q` or on any cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Memory enable; gates both decoders |
| addr_ld | input | 1 | Load strobe for the address register |
| addr_in | input | ADDR_W | Address to latch |
| data_ld | input | 1 | Load strobe for the data register from outside |
| data_in | input | DATA_W | Value to latch into the data register |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| mar_q | output | ADDR_W | Current address register |
| mdr_q | output | DATA_W | Current data register |
| row_sel | output | 2^(ADDR_W/2) | One-hot row select lines |
| col_sel | output | 2^(ADDR_W/2) | One-hot column select lines |

## Verification
Register loads have a one-edge latency. A value latched into `mar_q` or `mdr_q` at one edge is visible afterwards. The select lines follow `mar_q` with no further delay, so they settle in the same cycle as the address. A read reports its cell one edge after the request. A written value is only observable through a later address load and read, which puts it two edges after the write. The bench drives every stimulus on the falling edge, waits for exactly one rising edge per operation, and samples on the next falling edge. Each expected value is therefore compared in the first cycle in which it is due.

// File: rtl/grid_ram.sv
module grid_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        addr_ld,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic                        data_ld,
  input  logic [DATA_W-1:0]           data_in,
  input  logic                        rd_req,
  input  logic                        wr_req,
  output logic [ADDR_W-1:0]           mar_q,
  output logic [DATA_W-1:0]           mdr_q,
  output logic [(1<<(ADDR_W/2))-1:0]  row_sel,
  output logic [(1<<(ADDR_W/2))-1:0]  col_sel
);
  localparam int HALF  = ADDR_W / 2;
  localparam int LINES = 1 << HALF;

  logic [HALF-1:0]   row_idx, col_idx;
  logic [DATA_W-1:0] cell_q [LINES][LINES];
  logic [DATA_W-1:0] rd_word;
  logic              rd_go, wr_go;

  assign row_idx = mar_q[ADDR_W-1:HALF];
  assign col_idx = mar_q[HALF-1:0];
  assign rd_go   = en & rd_req;
  assign wr_go   = en & wr_req & ~rd_req;

  assign row_sel = en ? ({{(LINES-1){1'b0}}, 1'b1} << row_idx) : '0;
  assign col_sel = en ? ({{(LINES-1){1'b0}}, 1'b1} << col_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mar_q <= '0;
    else if (addr_ld) mar_q <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mdr_q <= '0;
    else if (rd_go)   mdr_q <= rd_word;
    else if (data_ld) mdr_q <= data_in;
  end

  for (genvar r = 0; r < LINES; r++) begin : g_row
    for (genvar c = 0; c < LINES; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cell_q[r][c] <= '0;
        else if (wr_go && row_sel[r] && col_sel[c]) cell_q[r][c] <= mdr_q;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < LINES; r++)
      for (int c = 0; c < LINES; c++)
        if (row_sel[r] && col_sel[c]) rd_word = rd_word | cell_q[r][c];
  end

  // R1
  mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld |=> mar_q == $past(addr_in));
  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(row_sel) == 1);
  // R3
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(col_sel) == 1);
  // R4
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (row_sel == '0) && (col_sel == '0));
  // R5
  rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_req) |=> mdr_q == $past(rd_word));
  // R7
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ld && !(en && rd_req)) |=> mdr_q == $past(data_in));
  // R10
  idle_mdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !data_ld) |=> $stable(mdr_q));
endmodule

// File: tb/grid_ram_tb_top.sv
`timescale 1ns/1ps
module grid_ram_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int H  = AW / 2;
  localparam int L  = 1 << H;
  localparam int NC = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, en, addr_ld, data_ld, rd_req, wr_req;
  logic [AW-1:0] addr_in, mar_q;
  logic [DW-1:0] data_in, mdr_q;
  logic [L-1:0]  row_sel, col_sel;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [NC];

  always #2.5 clk = ~clk;

  grid_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_ld(addr_ld), .addr_in(addr_in),
    .data_ld(data_ld), .data_in(data_in), .rd_req(rd_req), .wr_req(wr_req),
    .mar_q(mar_q), .mdr_q(mdr_q), .row_sel(row_sel), .col_sel(col_sel));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_ld = 1'b1; addr_in = a; cyc(); addr_ld = 1'b0;
  endtask

  task automatic load_data(input logic [DW-1:0] d);
    data_ld = 1'b1; data_in = d; cyc(); data_ld = 1'b0;
  endtask

  task automatic do_read();
    rd_req = 1'b1; cyc(); rd_req = 1'b0;
  endtask

  task automatic do_write();
    wr_req = 1'b1; cyc(); wr_req = 1'b0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, input string tag);
    load_addr(a);
    do_read();
    chk(mdr_q == model[a], tag, 32'(mdr_q), 32'(model[a]));
  endtask

  task automatic write_at(input logic [AW-1:0] a, input logic [DW-1:0] d);
    load_addr(a);
    load_data(d);
    do_write();
    model[a] = d;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; addr_ld = 1'b0; data_ld = 1'b0;
    rd_req = 1'b0; wr_req = 1'b0; addr_in = '0; data_in = '0;
    for (int i = 0; i < NC; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state; R4 lines low with en low
    chk(mar_q == '0, "R9 mar", 32'(mar_q), 0);
    chk(mdr_q == '0, "R9 mdr", 32'(mdr_q), 0);
    chk(row_sel == '0 && col_sel == '0, "R4 idle lines", 32'({row_sel, col_sel}), 0);

    // R1 hold, R4 after load with en low
    load_addr(8'h5A);
    cyc();
    chk(mar_q == 8'h5A, "R1 hold", 32'(mar_q), 32'h5A);
    chk(row_sel == '0 && col_sel == '0, "R4 en low", 32'({row_sel, col_sel}), 0);

    en = 1'b1;
    // R2 R3 decode sweep, R9 every cell zero after reset, R5
    for (int a = 0; a < NC; a++) begin
      load_addr(AW'(a));
      chk(mar_q == AW'(a), "R1 load", 32'(mar_q), 32'(a));
      chk(row_sel == (L'(1) << (a / L)), "R2 row", 32'(row_sel), 32'(L'(1) << (a / L)));
      chk(col_sel == (L'(1) << (a % L)), "R3 col", 32'(col_sel), 32'(L'(1) << (a % L)));
      do_read();
      chk(mdr_q == '0, "R9 cell clear", 32'(mdr_q), 0);
    end

    // R6 fill every cell with a computed pattern, then read back (R5)
    for (int a = 0; a < NC; a++) write_at(AW'(a), DW'((a * 37 + 11) & 8'hFF));
    for (int a = 0; a < NC; a++) read_at(AW'(a), "R6 readback");

    // R5 read is non-destructive: repeat the read
    load_addr(8'h33);
    do_read();
    do_read();
    chk(mdr_q == model[8'h33], "R5 second read", 32'(mdr_q), 32'(model[8'h33]));

    // R6 neighbours untouched
    write_at(8'h55, 8'hC3);
    read_at(8'h55, "R6 target");
    read_at(8'h54, "R6 left");
    read_at(8'h56, "R6 right");
    read_at(8'h45, "R6 above");
    read_at(8'h65, "R6 below");

    // R7 data load, then read beats data load
    load_data(8'h9E);
    chk(mdr_q == 8'h9E, "R7 data load", 32'(mdr_q), 32'h9E);
    load_addr(8'h10);
    data_ld = 1'b1; data_in = 8'h01; rd_req = 1'b1;
    cyc();
    data_ld = 1'b0; rd_req = 1'b0;
    chk(mdr_q == model[8'h10], "R7 read priority", 32'(mdr_q), 32'(model[8'h10]));

    // R8 read and write together
    load_addr(8'hA7);
    load_data(8'h5C);
    rd_req = 1'b1; wr_req = 1'b1;
    cyc();
    rd_req = 1'b0; wr_req = 1'b0;
    chk(mdr_q == model[8'hA7], "R8 read taken", 32'(mdr_q), 32'(model[8'hA7]));
    load_data(8'h5C);
    do_read();
    chk(mdr_q == model[8'hA7], "R8 cell kept", 32'(mdr_q), 32'(model[8'hA7]));

    // R10 requests ignored with en low
    load_addr(8'hE2);
    load_data(8'h77);
    en = 1'b0;
    do_write();
    do_read();
    chk(mdr_q == 8'h77, "R10 mdr kept", 32'(mdr_q), 32'h77);
    en = 1'b1;
    read_at(8'hE2, "R10 cell kept");

    // R6 corner addresses
    write_at(8'h00, 8'hFF);
    write_at(8'hFF, 8'h01);
    read_at(8'h00, "R6 first");
    read_at(8'hFF, "R6 last");
    read_at(8'h0F, "R6 row end");
    read_at(8'hF0, "R6 col start");

    finish_run();
  end
endmodule